// File: doc/BRIEF.md
# Round-Robin Request/Grant/Busy Bus Arbiter

This block decides which of several masters on one shared bus may take ownership next. Each master pulls its own active-low request line low when it wants the bus. The arbiter answers by pulling that master's active-low grant line low. All masters share one active-low busy line, and the bus is free while that line is high. A granted master waits for the bus to be free, then pulls busy low and releases its request. The arbiter sees busy go low and withdraws the grant. It issues no further grant until busy returns high.

When several masters request together, the winner is the first requester after the most recently granted master, taken in circular index order. If a granted master never takes the bus, its grant is withdrawn after a parameterized number of cycles. Arbitration then starts again, and the master that timed out goes to the back of the rotation. All inputs pass through one register stage before they are used. The grant lines come straight from flops.

Top module: `rr_bus_arbiter`

## Requirements
- R1: During reset and on the first cycles after it, every grantN bit is high (no grant).
- R2: When the bus is free and at least one reqN bit is low, a grant is driven low on the second rising edge after the request appears (one edge to register the input, one to register the grant).
- R3: At no time is more than one grantN bit low.
- R4: While busyN is low as registered by the arbiter and no grant is active, no new grant is issued, however many requests are pending.
- R5: Among simultaneous requesters, the grant goes to the lowest index strictly after the last granted index, wrapping from NUM_MASTERS-1 to 0. After reset the search starts at index 0.
- R6: When busyN goes low while a grant is active, the grant is withdrawn on the second rising edge after busyN falls.
- R7: A grant whose master has not pulled busyN low stays active for exactly TIMEOUT cycles (default 16) and is then withdrawn.
- R8: After an owner releases busyN, a pending request is granted on the second rising edge after busyN rises, and not earlier.
- R9: A master whose grant timed out counts as the last granted index, so another pending requester wins the following arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | NUM_MASTERS | Active-low bus request, one bit per master |
| busyN | input | 1 | Shared active-low bus-busy line |
| grantN | output | NUM_MASTERS | Active-low bus grant, one bit per master, registered |

## Verification
Two events can arrive in the same cycle: the granted master claiming the bus, and the grant-hold counter reaching its limit. They also collide with fresh requests that arrive while the bus is held. The bench creates these collisions by letting random masters claim late or not at all, and by holding busy across many pending requests. A reference model in the bench predicts the grant vector for every cycle. It is built from the timing stated in the requirements, and the design's grant output is compared with it on each falling edge. Directed sequences pin down the exact edges for claim, release, timeout and the rotation that follows a timeout.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_GRANTED = 1'b1
  } arbState_e;

  typedef struct packed {
    logic loadGrant;   // capture round-robin winner into grant register
    logic dropGrant;   // clear the grant register
    logic countHold;   // advance the grant-hold timer
  } ctrlStrobes_t;

endpackage

// File: rtl/rr_arb_datapath.sv
module rr_arb_datapath
  import rr_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int TIMEOUT     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqN,
  input  logic                   busyN,
  input  ctrlStrobes_t           strobe,
  output logic [NUM_MASTERS-1:0] grantN,
  output logic                   anyReq,
  output logic                   busyQ,
  output logic                   timeUp
);

  localparam int IDXW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int TW   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [NUM_MASTERS-1:0] reqQ;
  logic [NUM_MASTERS-1:0] grantQ;
  logic [NUM_MASTERS-1:0] winVec;
  logic [IDXW-1:0]        lastQ;
  logic [IDXW-1:0]        winIdx;
  logic [TW-1:0]          timerQ;

  // input capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= '0;
      busyQ <= 1'b0;
    end else begin
      reqQ  <= ~reqN;
      busyQ <= ~busyN;
    end
  end

  assign anyReq = |reqQ;

  // round-robin pick: first requester strictly after lastQ
  always_comb begin
    logic found;
    int   idx;
    found  = 1'b0;
    winIdx = lastQ;
    for (int off = 1; off <= NUM_MASTERS; off++) begin
      idx = (int'(lastQ) + off) % NUM_MASTERS;
      if (!found && reqQ[idx]) begin
        found  = 1'b1;
        winIdx = IDXW'(idx);
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_win
      assign winVec[g] = anyReq && (winIdx == IDXW'(g));
    end
  endgenerate

  // grant register and rotation pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= '0;
      lastQ  <= IDXW'(NUM_MASTERS - 1);
    end else if (strobe.loadGrant) begin
      grantQ <= winVec;
      lastQ  <= winIdx;
    end else if (strobe.dropGrant) begin
      grantQ <= '0;
    end
  end

  // grant-hold timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strobe.loadGrant) begin
      timerQ <= '0;
    end else if (strobe.countHold) begin
      timerQ <= timerQ + 1'b1;
    end
  end

  assign timeUp = (timerQ == TW'(TIMEOUT - 1));
  assign grantN = ~grantQ;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantQ) <= 1); // R3

  AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ == '0 && busyQ) |=> (grantQ == '0)); // R4

  AST_DROP_ON_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0 && busyQ) |=> (grantQ == '0)); // R6

  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ == '0 && anyReq && !busyQ) |=> (grantQ != '0)); // R2

endmodule

// File: rtl/rr_arb_control.sv
module rr_arb_control
  import rr_arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyReq,
  input  logic         busyQ,
  input  logic         timeUp,
  output ctrlStrobes_t strobe
);

  arbState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (anyReq && !busyQ) begin
          strobe.loadGrant = 1'b1;
          stateD           = ST_GRANTED;
        end
      end
      ST_GRANTED: begin
        if (busyQ || timeUp) begin
          strobe.dropGrant = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          strobe.countHold = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GRANTED && timeUp) |=> (stateQ == ST_IDLE)); // R7

endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
  import rr_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int TIMEOUT     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqN,
  input  logic                   busyN,
  output logic [NUM_MASTERS-1:0] grantN
);

  ctrlStrobes_t strobe;
  logic         anyReq;
  logic         busyQ;
  logic         timeUp;

  rr_arb_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyReq (anyReq),
    .busyQ  (busyQ),
    .timeUp (timeUp),
    .strobe (strobe)
  );

  rr_arb_datapath #(
    .NUM_MASTERS (NUM_MASTERS),
    .TIMEOUT     (TIMEOUT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .reqN   (reqN),
    .busyN  (busyN),
    .strobe (strobe),
    .grantN (grantN),
    .anyReq (anyReq),
    .busyQ  (busyQ),
    .timeUp (timeUp)
  );

endmodule

// File: tb/sim_rr_bus_arbiter.sv
module sim_rr_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int TMO        = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqDrv = '0;
  logic [N-1:0] busyDrv = '0;
  logic [N-1:0] reqN;
  logic         busyN;
  logic [N-1:0] grantN;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  bit  modelOn = 1'b0;

  assign reqN  = ~reqDrv;
  assign busyN = ~(|busyDrv);

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_bus_arbiter #(.NUM_MASTERS(N), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rstN(rstN), .reqN(reqN), .busyN(busyN), .grantN(grantN)
  );

  // ---------------- reference model ----------------
  function automatic int pickNext(int last, logic [N-1:0] mask);
    for (int off = 1; off <= N; off++) begin
      if (mask[(last + off) % N]) return (last + off) % N;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] grantVecN(int idx);
    logic [N-1:0] v;
    v = '1;
    if (idx >= 0) v[idx] = 1'b0;
    return v;
  endfunction

  int           mGrant, mLast, mTimer;
  logic [N-1:0] mReq;
  logic         mBusy;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mGrant = -1; mLast = N - 1; mTimer = 0; mReq = '0; mBusy = 1'b0;
    end else begin
      if (mGrant < 0) begin
        if (!mBusy && mReq != '0) begin
          mGrant = pickNext(mLast, mReq);
          mLast  = mGrant;
          mTimer = 0;
        end
      end else if (mBusy || mTimer == TMO - 1) begin
        mGrant = -1;
      end else begin
        mTimer++;
      end
      mReq  = ~reqN;
      mBusy = ~busyN;
    end
  end

  task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s grantN actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && modelOn) begin
      logic [N-1:0] e;
      e = grantVecN(mGrant);
      if ($countones(~grantN) > 1)
        check(1'b0, "R3", grantN, e);
      else if (mGrant < 0)
        check(grantN == e, "R6", grantN, e);
      else
        check(grantN == e, "R5", grantN, e);
    end
  end

  // ---------------- random masters ----------------
  int holdCnt [N];

  task automatic stepMasters(int claimPct);
    logic [N-1:0] g;
    logic         free;
    g    = ~grantN;
    free = busyN;
    for (int m = 0; m < N; m++) begin
      if (busyDrv[m]) begin
        if (holdCnt[m] == 0) busyDrv[m] = 1'b0;
        else holdCnt[m]--;
      end else if (g[m] && free && ($urandom % 100) < claimPct) begin
        busyDrv[m] = 1'b1;
        reqDrv[m]  = 1'b0;
        holdCnt[m] = $urandom % 6;
        free       = 1'b0;
      end else if (!reqDrv[m] && ($urandom % 100) < 30) begin
        reqDrv[m] = 1'b1;
      end
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h1234_5678));
    for (int m = 0; m < N; m++) holdCnt[m] = 0;
    waitNeg(3);
    check(grantN == '1, "R1", grantN, '1);
    rstN = 1'b1;
    waitNeg(1);
    check(grantN == '1, "R1", grantN, '1);
    modelOn = 1'b1;

    // R2: lone request from master 2
    reqDrv[2] = 1'b1;
    waitNeg(1);
    check(grantN == '1, "R2", grantN, '1);
    waitNeg(1);
    check(grantN == 4'b1011, "R2", grantN, 4'b1011);

    // R6: master 2 claims
    busyDrv[2] = 1'b1; reqDrv[2] = 1'b0;
    waitNeg(1);
    check(grantN == 4'b1011, "R6", grantN, 4'b1011);
    reqDrv[0] = 1'b1; reqDrv[3] = 1'b1;
    waitNeg(1);
    check(grantN == '1, "R6", grantN, '1);

    // R4: requests pending while bus held
    for (int k = 0; k < 5; k++) begin
      waitNeg(1);
      check(grantN == '1, "R4", grantN, '1);
    end

    // R8 and R5: release, next after 2 is 3
    busyDrv[2] = 1'b0;
    waitNeg(1);
    check(grantN == '1, "R8", grantN, '1);
    waitNeg(1);
    check(grantN == 4'b0111, "R5", grantN, 4'b0111);
    busyDrv[3] = 1'b1; reqDrv[3] = 1'b0;
    waitNeg(3);
    busyDrv[3] = 1'b0;
    waitNeg(2);
    check(grantN == 4'b1110, "R5", grantN, 4'b1110);
    busyDrv[0] = 1'b1; reqDrv[0] = 1'b0;
    waitNeg(3);
    busyDrv[0] = 1'b0;
    waitNeg(3);

    // R7 and R9: master 1 never claims
    reqDrv[1] = 1'b1;
    waitNeg(2);
    check(grantN == 4'b1101, "R7", grantN, 4'b1101);
    reqDrv[2] = 1'b1;
    for (int k = 1; k < TMO; k++) begin
      waitNeg(1);
      check(grantN == 4'b1101, "R7", grantN, 4'b1101);
    end
    waitNeg(1);
    check(grantN == '1, "R7", grantN, '1);
    waitNeg(1);
    check(grantN == 4'b1011, "R9", grantN, 4'b1011);
    reqDrv = '0;
    waitNeg(TMO + 4);

    // random phase with late and absent claims
    for (int c = 0; c < 4000; c++) begin
      waitNeg(1);
      stepMasters((c < 2000) ? 85 : 40);
    end
    reqDrv = '0; busyDrv = '0;
    waitNeg(TMO + 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule